// File: doc/BRIEF.md
# Banked queue interrupt aggregator

This block gathers interrupt events from a set of hardware queues and condenses them into one CPU interrupt line, with an optional direct output per queue. The queues are grouped in banks of 32, one bit per queue in every bank register. Each queue reports four event classes:

- not-empty, a live level;
- low watermark, a one-cycle pulse;
- high watermark, a one-cycle pulse;
- timer, a one-cycle pulse.

Each bank keeps a status and a mask word for every class. The masked result of every queue that is not routed to its own output folds into one status bit per bank. A top-level mask then gates those bank bits onto a registered CPU interrupt.

Software reaches all state through a plain register port: a write strobe with address and data, and a read result that appears one cycle after the address. Each class mask can be written in three ways: directly, through a set alias that ORs data in, and through a clear alias that removes bits.

A queue whose bit is set in the bank's route register leaves the bank aggregate. It then raises its own output whenever any of its masked classes is pending.

Top module: `qirq_aggregator`

## Requirements
- R1: The word address is {bank index, 5-bit offset}. Bank index NUM_BANKS selects the top-level page. `reg_rdata` shows the addressed word one cycle after `reg_addr` is presented. Offsets that are not listed in R2, R3, R5, R6, R8 and R9 read as zero: 0x06, 0x07, offset bit 2 set with bits 4:3 non-zero, and top-level offsets other than 0x00 and 0x01.
- R2: Bank offset 0x00 reads the not-empty level, sampled one cycle earlier. Offset 0x01 reads that level ANDed with the not-empty mask.
- R3: Bank offsets 0x02 (low watermark), 0x03 (high watermark) and 0x04 (timer) hold sticky status. A one-cycle event pulse sets the queue's bit, and the bit stays set after the pulse ends.
- R4: Writing 1s to a sticky status offset clears those bits and leaves the others unchanged. An event that arrives in the same cycle as a clear of the same bit leaves the bit set.
- R5: Offset 0x08+c is the direct mask for class c (0 not-empty, 1 low watermark, 2 high watermark, 3 timer). A write replaces the whole word.
- R6: Offset 0x10+c is a set alias: a write ORs the data into mask c. Offset 0x18+c is a clear alias: a write clears the mask c bits where the data is 1. Both aliases read back mask c.
- R7: Top-level offset 0x00 bit b reads as 1 when any queue in bank b is not routed and has some class whose status AND mask is 1.
- R8: Top-level offset 0x01 is the bank mask, one bit per bank. `cpu_irq` is high in the cycle after some top-level status bit and its mask bit are both 1, and is low otherwise.
- R9: Bank offset 0x05 is the route register. A routed queue drives `q_irq[bank*32+queue]` high while any of its classes has status AND mask set. A queue that is not routed keeps its `q_irq` bit low.
- R10: After reset, all masks, sticky status, route bits, the bank mask, `cpu_irq`, `q_irq` and `reg_rdata` are zero.
- R11: Writes to read-only offsets have no effect. The read-only offsets are bank offsets 0x00 and 0x01 and top-level offset 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ne_level | input | NUM_BANKS*QPB | Live not-empty level per queue |
| lwm_evt | input | NUM_BANKS*QPB | Low-watermark event pulse per queue |
| hwm_evt | input | NUM_BANKS*QPB | High-watermark event pulse per queue |
| tmr_evt | input | NUM_BANKS*QPB | Timer event pulse per queue |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | SEL_W+5 | Word address {bank, offset} |
| reg_wdata | input | QPB | Write data |
| reg_rdata | output | QPB | Read data, one cycle after the address |
| cpu_irq | output | 1 | Aggregated CPU interrupt, registered |
| q_irq | output | NUM_BANKS*QPB | Per-queue interrupt for routed queues |

## Verification
Two functions can land on the same sticky bit in one clock: a write-1-to-clear from software and a fresh event pulse from the queue. The bench produces this collision on purpose. It writes all ones to a bank's low-watermark status in the same cycle that one queue's event pulse is high, and then reads the word back. The behavioural model applies the clear before the event, so the word must read back with that one bit still set. The random phase also produces alias writes that overlap with events and routing changes, and the model compares every output on every clock.

// File: rtl/qirq_pkg.sv
package qirq_pkg;
  localparam int OFF_W      = 5;
  localparam int NUM_CLASS  = 4;
  localparam int NUM_STICKY = 3;

  // offset[4:3] selects the page kind inside a bank
  localparam logic [1:0] KIND_STAT = 2'd0;
  localparam logic [1:0] KIND_MASK = 2'd1;
  localparam logic [1:0] KIND_SET  = 2'd2;
  localparam logic [1:0] KIND_CLR  = 2'd3;

  // offset[2:0] inside the status page
  localparam logic [2:0] SEL_NE_RAW  = 3'd0;
  localparam logic [2:0] SEL_NE_PEND = 3'd1;
  localparam logic [2:0] SEL_LWM     = 3'd2;
  localparam logic [2:0] SEL_HWM     = 3'd3;
  localparam logic [2:0] SEL_TMR     = 3'd4;
  localparam logic [2:0] SEL_ROUTE   = 3'd5;

  // top-level page offsets
  localparam logic [OFF_W-1:0] TOP_OFF_STATUS = 5'd0;
  localparam logic [OFF_W-1:0] TOP_OFF_MASK   = 5'd1;
endpackage

// File: rtl/qirq_bank.sv
module qirq_bank
  import qirq_pkg::*;
#(
  parameter int QPB = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] off,
  input  logic [QPB-1:0]   wdata,
  input  logic [QPB-1:0]   ne_level,
  input  logic [QPB-1:0]   lwm_evt,
  input  logic [QPB-1:0]   hwm_evt,
  input  logic [QPB-1:0]   tmr_evt,
  output logic [QPB-1:0]   rd_data,
  output logic             bank_pend,
  output logic [QPB-1:0]   q_irq
);
  logic [1:0] kind;
  logic [2:0] sel;
  assign kind = off[4:3];
  assign sel  = off[2:0];

  logic [QPB-1:0]                   ne_q;
  logic [QPB-1:0]                   route_q;
  logic [NUM_CLASS-1:0][QPB-1:0]    mask_q, mask_d;
  logic [NUM_CLASS-1:0]             mask_en;
  logic [NUM_STICKY-1:0][QPB-1:0]   stk_q, stk_d;
  logic [NUM_STICKY-1:0]            stk_en;
  logic [NUM_STICKY-1:0][QPB-1:0]   evt_v;
  logic [NUM_CLASS-1:0][QPB-1:0]    cls_st;
  logic [QPB-1:0]                   any_pend;
  logic                             mask_hit;
  logic                             route_we;

  assign evt_v    = {tmr_evt, hwm_evt, lwm_evt};
  assign mask_hit = wr_en && (kind != KIND_STAT) && !sel[2];
  assign route_we = wr_en && (kind == KIND_STAT) && (sel == SEL_ROUTE);

  // next state: masks (direct, set alias, clear alias)
  always_comb begin
    mask_d  = mask_q;
    mask_en = '0;
    for (int c = 0; c < NUM_CLASS; c++) begin
      if (mask_hit && (sel[1:0] == 2'(c))) begin
        mask_en[c] = 1'b1;
        unique case (kind)
          KIND_MASK: mask_d[c] = wdata;
          KIND_SET:  mask_d[c] = mask_q[c] | wdata;
          KIND_CLR:  mask_d[c] = mask_q[c] & ~wdata;
          default:   mask_d[c] = mask_q[c];
        endcase
      end
    end
  end

  // next state: sticky status, clear first then event so an event is never lost
  always_comb begin
    logic [QPB-1:0] clr;
    for (int k = 0; k < NUM_STICKY; k++) begin
      clr = (wr_en && (kind == KIND_STAT) && (sel == SEL_LWM + 3'(k))) ? wdata : '0;
      stk_d[k]  = (stk_q[k] & ~clr) | evt_v[k];
      stk_en[k] = (|clr) || (|evt_v[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ne_q    <= '0;
      route_q <= '0;
      mask_q  <= '0;
      stk_q   <= '0;
    end else begin
      ne_q <= ne_level;
      if (route_we) route_q <= wdata;
      for (int c = 0; c < NUM_CLASS; c++)
        if (mask_en[c]) mask_q[c] <= mask_d[c];
      for (int k = 0; k < NUM_STICKY; k++)
        if (stk_en[k]) stk_q[k] <= stk_d[k];
    end
  end

  // per-queue pending across the four classes
  assign cls_st = {stk_q[2], stk_q[1], stk_q[0], ne_q};
  always_comb begin
    any_pend = '0;
    for (int c = 0; c < NUM_CLASS; c++)
      any_pend = any_pend | (cls_st[c] & mask_q[c]);
  end

  assign q_irq     = any_pend & route_q;
  assign bank_pend = |(any_pend & ~route_q);

  // read mux
  always_comb begin
    rd_data = '0;
    if (kind == KIND_STAT) begin
      unique case (sel)
        SEL_NE_RAW:  rd_data = ne_q;
        SEL_NE_PEND: rd_data = ne_q & mask_q[0];
        SEL_LWM:     rd_data = stk_q[0];
        SEL_HWM:     rd_data = stk_q[1];
        SEL_TMR:     rd_data = stk_q[2];
        SEL_ROUTE:   rd_data = route_q;
        default:     rd_data = '0;
      endcase
    end else if (!sel[2]) begin
      rd_data = mask_q[sel[1:0]];
    end
  end

  // a pulse always leaves its sticky bit set
  assert_evt_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stk_q[0] & $past(lwm_evt)) == $past(lwm_evt)));
  assert_tmr_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stk_q[2] & $past(tmr_evt)) == $past(tmr_evt)));
  // write-1-to-clear without a competing event clears the written bits
  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == KIND_STAT && sel == SEL_HWM && hwm_evt == '0)
      |=> ((stk_q[1] & $past(wdata)) == '0));
  // aliases
  assert_set_alias_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == KIND_SET && !sel[2])
      |=> ((mask_q[$past(sel[1:0])] & $past(wdata)) == $past(wdata)));
  assert_clr_alias_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == KIND_CLR && !sel[2])
      |=> ((mask_q[$past(sel[1:0])] & $past(wdata)) == '0));
endmodule

// File: rtl/qirq_root.sv
module qirq_root
  import qirq_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [OFF_W-1:0]     off,
  input  logic [NUM_BANKS-1:0] wdata,
  input  logic [NUM_BANKS-1:0] bank_pend,
  output logic [NUM_BANKS-1:0] rd_data,
  output logic                 cpu_irq
);
  logic [NUM_BANKS-1:0] top_mask_q, top_mask_d;
  logic                 top_mask_en;
  logic                 irq_d, irq_q;

  always_comb begin
    top_mask_en = wr_en && (off == TOP_OFF_MASK);
    top_mask_d  = wdata;
    irq_d       = |(bank_pend & top_mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_mask_q <= '0;
      irq_q      <= 1'b0;
    end else begin
      if (top_mask_en) top_mask_q <= top_mask_d;
      irq_q <= irq_d;
    end
  end

  assign cpu_irq = irq_q;

  always_comb begin
    unique case (off)
      TOP_OFF_STATUS: rd_data = bank_pend;
      TOP_OFF_MASK:   rd_data = top_mask_q;
      default:        rd_data = '0;
    endcase
  end

  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(bank_pend & top_mask_q)) |=> cpu_irq);
  assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(bank_pend & top_mask_q)) |=> !cpu_irq);
endmodule

// File: rtl/qirq_aggregator.sv
module qirq_aggregator
  import qirq_pkg::*;
#(
  parameter  int NUM_BANKS = 3,
  parameter  int QPB       = 32,
  localparam int NQ        = NUM_BANKS * QPB,
  localparam int SEL_W     = $clog2(NUM_BANKS + 1),
  localparam int ADDR_W    = SEL_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NQ-1:0]     ne_level,
  input  logic [NQ-1:0]     lwm_evt,
  input  logic [NQ-1:0]     hwm_evt,
  input  logic [NQ-1:0]     tmr_evt,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [QPB-1:0]    reg_wdata,
  output logic [QPB-1:0]    reg_rdata,
  output logic              cpu_irq,
  output logic [NQ-1:0]     q_irq
);
  logic [SEL_W-1:0]     bank_sel;
  logic [OFF_W-1:0]     off;
  logic [NUM_BANKS-1:0] bank_pend;
  logic [QPB-1:0]       bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] root_rd;
  logic [QPB-1:0]       rd_d, rd_q;

  assign bank_sel = reg_addr[ADDR_W-1:OFF_W];
  assign off      = reg_addr[OFF_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    qirq_bank #(.QPB(QPB)) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr && (bank_sel == SEL_W'(b))),
      .off       (off),
      .wdata     (reg_wdata),
      .ne_level  (ne_level[b*QPB +: QPB]),
      .lwm_evt   (lwm_evt[b*QPB +: QPB]),
      .hwm_evt   (hwm_evt[b*QPB +: QPB]),
      .tmr_evt   (tmr_evt[b*QPB +: QPB]),
      .rd_data   (bank_rd[b]),
      .bank_pend (bank_pend[b]),
      .q_irq     (q_irq[b*QPB +: QPB])
    );
  end

  qirq_root #(.NUM_BANKS(NUM_BANKS)) root_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr && (bank_sel == SEL_W'(NUM_BANKS))),
    .off       (off),
    .wdata     (reg_wdata[NUM_BANKS-1:0]),
    .bank_pend (bank_pend),
    .rd_data   (root_rd),
    .cpu_irq   (cpu_irq)
  );

  always_comb begin
    rd_d = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_sel == SEL_W'(b)) rd_d = bank_rd[b];
    if (bank_sel == SEL_W'(NUM_BANKS)) rd_d = QPB'(root_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign reg_rdata = rd_q;

  // a read of an empty offset returns zero one cycle later
  assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel < SEL_W'(NUM_BANKS) && off[4:3] == KIND_STAT && off[2:1] == 2'b11)
      |=> (reg_rdata == '0));
endmodule

// File: tb/qirq_aggregator_tb_top.sv
`timescale 1ns/1ps
module qirq_aggregator_tb_top;
  localparam int NB = 3;
  localparam int NQ = 96;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NQ-1:0] ne_level, lwm_evt, hwm_evt, tmr_evt;
  logic          reg_wr;
  logic [6:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic          cpu_irq;
  logic [NQ-1:0] q_irq;

  always #10 clk = ~clk;

  qirq_aggregator dut_i (
    .clk(clk), .rst_n(rst_n), .ne_level(ne_level), .lwm_evt(lwm_evt),
    .hwm_evt(hwm_evt), .tmr_evt(tmr_evt), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_irq(cpu_irq), .q_irq(q_irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_mask [NB][4];
  logic [31:0] m_stk  [NB][3];
  logic [31:0] m_ne   [NB];
  logic [31:0] m_route[NB];
  logic [NB-1:0] m_tmask;
  logic [31:0] m_rdata;
  logic        m_cpu;

  function automatic logic [31:0] pend_of(int b);
    logic [31:0] p;
    p = (m_ne[b] & m_mask[b][0]) | (m_stk[b][0] & m_mask[b][1]) |
        (m_stk[b][1] & m_mask[b][2]) | (m_stk[b][2] & m_mask[b][3]);
    return p;
  endfunction

  function automatic logic [NB-1:0] top_status();
    logic [NB-1:0] t;
    for (int b = 0; b < NB; b++) t[b] = |(pend_of(b) & ~m_route[b]);
    return t;
  endfunction

  function automatic logic [NQ-1:0] qirq_model();
    logic [NQ-1:0] q;
    for (int b = 0; b < NB; b++) q[b*32 +: 32] = pend_of(b) & m_route[b];
    return q;
  endfunction

  function automatic logic [31:0] read_model(logic [6:0] a);
    int b, o;
    b = int'(a[6:5]);
    o = int'(a[4:0]);
    if (b == NB) begin
      if (o == 0) return 32'(top_status());
      if (o == 1) return 32'(m_tmask);
      return 32'h0;
    end
    if (o == 0) return m_ne[b];
    if (o == 1) return m_ne[b] & m_mask[b][0];
    if (o >= 2 && o <= 4) return m_stk[b][o-2];
    if (o == 5) return m_route[b];
    if (o >= 8 && (o % 8) < 4) return m_mask[b][o % 8];
    return 32'h0;
  endfunction

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      for (int c = 0; c < 4; c++) m_mask[b][c] = '0;
      for (int k = 0; k < 3; k++) m_stk[b][k] = '0;
      m_ne[b] = '0;
      m_route[b] = '0;
    end
    m_tmask = '0;
    m_rdata = '0;
    m_cpu   = 1'b0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      logic [31:0] nrd;
      logic        ncpu;
      int b, o, c;
      nrd  = read_model(reg_addr);
      ncpu = |(top_status() & m_tmask);
      b = int'(reg_addr[6:5]);
      o = int'(reg_addr[4:0]);
      if (reg_wr) begin
        if (b == NB) begin
          if (o == 1) m_tmask = reg_wdata[NB-1:0];
        end else if (o >= 2 && o <= 4) m_stk[b][o-2] = m_stk[b][o-2] & ~reg_wdata;
        else if (o == 5) m_route[b] = reg_wdata;
        else if (o >= 8 && (o % 8) < 4) begin
          c = o % 8;
          if (o < 16)      m_mask[b][c] = reg_wdata;
          else if (o < 24) m_mask[b][c] = m_mask[b][c] | reg_wdata;
          else             m_mask[b][c] = m_mask[b][c] & ~reg_wdata;
        end
      end
      for (int i = 0; i < NB; i++) begin
        m_stk[i][0] = m_stk[i][0] | lwm_evt[i*32 +: 32];
        m_stk[i][1] = m_stk[i][1] | hwm_evt[i*32 +: 32];
        m_stk[i][2] = m_stk[i][2] | tmr_evt[i*32 +: 32];
        m_ne[i]     = ne_level[i*32 +: 32];
      end
      m_rdata = nrd;
      m_cpu   = ncpu;
    end
  end

  // ---------------- per-cycle comparison ----------------
  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R10";
  bit    finished = 1'b0;

  always @(negedge clk) begin
    if (!finished) begin
      vectors++;
      if (reg_rdata !== m_rdata) begin
        miscompares++;
        $display("FAIL %s reg_rdata act=%h exp=%h t=%0t", cur_req, reg_rdata, m_rdata, $time);
      end
      if (cpu_irq !== m_cpu) begin
        miscompares++;
        $display("FAIL %s cpu_irq act=%b exp=%b t=%0t", cur_req, cpu_irq, m_cpu, $time);
      end
      if (q_irq !== qirq_model()) begin
        miscompares++;
        $display("FAIL %s q_irq act=%h exp=%h t=%0t", cur_req, q_irq, qirq_model(), $time);
      end
    end
  end

  // ---------------- stimulus helpers (start and end at a falling edge) ----------------
  function automatic logic [6:0] A(int b, int o);
    return 7'(b * 32 + o);
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [6:0] a);
    reg_addr = a;
    idle(2);
  endtask

  task automatic pulse(int cls, int q);
    case (cls)
      1: lwm_evt[q] = 1'b1;
      2: hwm_evt[q] = 1'b1;
      default: tmr_evt[q] = 1'b1;
    endcase
    @(negedge clk);
    lwm_evt = '0; hwm_evt = '0; tmr_evt = '0;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired in %s", cur_req);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    ne_level = '0; lwm_evt = '0; hwm_evt = '0; tmr_evt = '0;
    idle(4);
    // R10: reset state, then reads of every page after release
    cur_req = "R10";
    rst_n = 1'b1;
    for (int o = 0; o < 32; o++) rd(A(0, o));
    rd(A(3, 0)); rd(A(3, 1));

    // R5: direct mask write replaces the word
    cur_req = "R5";
    wr(A(0, 8+1), 32'hA5A5_0F0F); rd(A(0, 8+1));
    wr(A(0, 8+1), 32'h0000_00F0); rd(A(0, 8+1));
    wr(A(2, 8+3), 32'hFFFF_0000); rd(A(2, 8+3));

    // R6: set and clear aliases, read through every alias
    cur_req = "R6";
    wr(A(1, 16+2), 32'h0000_00FF); wr(A(1, 16+2), 32'h00FF_0000);
    rd(A(1, 8+2)); rd(A(1, 16+2));
    wr(A(1, 24+2), 32'h0000_000F); rd(A(1, 24+2));

    // R2: not-empty raw level and masked view
    cur_req = "R2";
    wr(A(2, 8+0), 32'h0000_FF00);
    ne_level[64 +: 32] = 32'h1234_5678;
    rd(A(2, 0)); rd(A(2, 1));
    ne_level = '0;
    rd(A(2, 0));

    // R3: sticky event status
    cur_req = "R3";
    pulse(1, 3); pulse(2, 40); pulse(3, 95);
    idle(3);
    rd(A(0, 2)); rd(A(1, 3)); rd(A(2, 4));

    // R4: write-1-to-clear, and collision with an event in the same cycle
    cur_req = "R4";
    pulse(1, 7); pulse(1, 9);
    wr(A(0, 2), 32'h0000_0080); rd(A(0, 2));
    reg_wr = 1'b1; reg_addr = A(1, 2); reg_wdata = 32'hFFFF_FFFF;
    lwm_evt[32 + 5] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; lwm_evt = '0;
    rd(A(1, 2));

    // R11: writes to read-only offsets leave state unchanged
    cur_req = "R11";
    ne_level[31:0] = 32'h0000_0003;
    wr(A(0, 8+0), 32'h0000_0001);
    wr(A(0, 0), 32'hFFFF_FFFF); rd(A(0, 0));
    wr(A(0, 1), 32'hFFFF_FFFF); rd(A(0, 1));
    wr(A(3, 0), 32'hFFFF_FFFF); rd(A(3, 0));
    ne_level = '0;

    // R7 / R8: bank status and gated CPU interrupt
    cur_req = "R7";
    wr(A(0, 8+1), 32'h0000_0008);
    rd(A(3, 0));
    cur_req = "R8";
    wr(A(3, 1), 32'h0000_0002); idle(3);
    wr(A(3, 1), 32'h0000_0001); idle(3);
    wr(A(0, 2), 32'h0000_0008); idle(3);
    wr(A(3, 1), 32'h0000_0000); idle(2);

    // R9: routing a queue to its own output removes it from the bank bit
    cur_req = "R9";
    wr(A(3, 1), 32'h0000_0007);
    wr(A(1, 8+3), 32'h0000_0300);
    pulse(3, 32 + 8); idle(2);
    wr(A(1, 5), 32'h0000_0100); idle(2);
    rd(A(3, 0));
    wr(A(1, 5), 32'h0000_0000); idle(2);

    // R1: unmapped offsets read zero
    cur_req = "R1";
    rd(A(0, 6)); rd(A(0, 7)); rd(A(1, 12)); rd(A(2, 20)); rd(A(3, 2)); rd(A(3, 31));

    // random mix, compared every clock
    cur_req = "R7";
    for (int n = 0; n < 4000; n++) begin
      reg_wr    = ($urandom % 4) == 0;
      reg_addr  = 7'($urandom);
      reg_wdata = $urandom;
      lwm_evt   = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
      hwm_evt   = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
      tmr_evt   = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
      if (($urandom % 8) == 0) ne_level = {$urandom, $urandom, $urandom};
      @(negedge clk);
    end
    reg_wr = 1'b0; lwm_evt = '0; hwm_evt = '0; tmr_evt = '0;
    idle(3);
    finish_run();
  end
endmodule